// File: doc/BRIEF.md
# Ethernet Receive Frame Check and Error Classifier

This block sits on the receive path behind the start-of-frame delimiter stripper. It accepts one byte per enabled cycle, with start and end markers, covering everything from the destination address through the four trailing check bytes. It runs the CRC-32 over the whole frame, check bytes included, and counts the bytes. It never takes the check bytes apart. A correct frame always leaves the same residue in the CRC register, so the frame is judged by one 32-bit compare at the last byte.

One cycle after the last byte, the block pulses a status word. The word holds a good flag and four error flags: CRC error, runt, giant and jabber. The CRC result and the length class are combined, so an oversized frame with a bad CRC is reported as jabber and not as a plain giant. Five saturating event counters track these outcomes. They can be read through a combinational address/data port and cleared together with a synchronous clear. The block only reports: it corrects nothing and drops nothing.

Top module: `fcs_rx_checker`

## Requirements
- R1: A frame of 64 bytes or more (check bytes included), no longer than the size limit, whose check bytes are correct, raises only `st_good` in its status cycle.
- R2: The CRC starts from all ones and uses polynomial 0x04C11DB7, shifting the register MSB first with each byte's bits fed LSB first. The check value is the complemented register with its 32 bits reversed, sent least significant byte first. A frame is CRC-good exactly when the complemented register after its last byte equals 0x38FB2284; otherwise `st_crc_err` is raised. Every single-bit flip, double-bit flip and burst of up to 32 bits in a good frame is flagged.
- R3: A frame shorter than 64 bytes raises `st_runt`, together with `st_crc_err` if its CRC also fails.
- R4: A CRC-good frame longer than 1518 bytes raises `st_giant`. The limit is 1522 bytes while `vlan_allow` is 1.
- R5: An oversized frame that fails the CRC raises `st_jabber` and `st_crc_err`, and leaves `st_giant` low.
- R6: `st_valid` and the flags are high only in the single cycle after the cycle in which a byte with `in_eof` is accepted. All flags are 0 in every other cycle, and `st_good` is never high together with an error flag.
- R7: The byte count saturates at 2^LEN_W−1, so a frame longer than that still counts as oversized.
- R8: On a status cycle each raised flag has added one to its counter. `rd_addr` 0 reads good, 1 CRC error, 2 runt, 3 giant and 4 jabber; addresses 5 to 7 read 0.
- R9: A counter at its all-ones value stays there when further events arrive.
- R10: `cnt_clr` zeroes all counters at the next edge. It wins over an increment in the same cycle, but the status pulse of that frame is still produced.
- R11: Cycles with `in_valid` low are ignored, even in the middle of a frame. A byte with `in_sof` restarts the CRC and the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame (last check byte) |
| in_byte | input | 8 | Frame byte |
| vlan_allow | input | 1 | Raises the size limit by four bytes |
| st_valid | output | 1 | Status cycle marker |
| st_good | output | 1 | Frame without error |
| st_crc_err | output | 1 | Residue mismatch |
| st_runt | output | 1 | Shorter than 64 bytes |
| st_giant | output | 1 | Oversized with good CRC |
| st_jabber | output | 1 | Oversized with bad CRC |
| cnt_clr | input | 1 | Synchronous counter clear |
| rd_addr | input | 3 | Counter select |
| rd_data | output | CNT_W | Selected counter value |

## Verification
Two things can happen in the same cycle: a counter clear and the end of a frame whose status would increment a counter. The bench raises `cnt_clr` on the very byte that carries `in_eof`. It then expects the status pulse for that frame, all counters read back as zero, and counting to resume from one on the next frame. A second overlap is within the status word itself: a frame can be both too long and CRC-bad. Length sweeps around 64, 1518 and 1522 bytes, each sent both intact and corrupted, show that this case ends as jabber plus CRC error and never as giant.

// File: rtl/fcs_chk_pkg.sv
package fcs_chk_pkg;

    localparam logic [31:0] CRC_POLY     = 32'h04C11DB7;
    localparam logic [31:0] CRC_PRESET   = 32'hFFFF_FFFF;
    localparam logic [31:0] GOOD_RESIDUE = 32'h38FB_2284;

    localparam int MIN_FRAME  = 64;
    localparam int MAX_FRAME  = 1518;
    localparam int TAG_EXTRA  = 4;
    localparam int EV_COUNT   = 5;
    localparam int RD_ADDR_W  = 3;

    typedef enum logic [2:0] {
        EV_GOOD   = 3'd0,
        EV_CRC    = 3'd1,
        EV_RUNT   = 3'd2,
        EV_GIANT  = 3'd3,
        EV_JABBER = 3'd4
    } evt_e;

    typedef struct packed {
        logic good;
        logic crc_err;
        logic runt;
        logic giant;
        logic jabber;
    } fcs_status_t;

    // One byte through the MSB-first register, byte bits taken LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/fcs_crc_engine.sv
module fcs_crc_engine
    import fcs_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_step,
    input  logic        in_first,
    input  logic [7:0]  in_data,
    output logic [31:0] crc_next
);
    logic [31:0] crc_q;

    assign crc_next = crc_step(in_first ? CRC_PRESET : crc_q, in_data);

    always_ff @(posedge clk) begin
        if (rst)          crc_q <= CRC_PRESET;
        else if (in_step) crc_q <= crc_next;
    end

    // R11: an idle cycle leaves the running remainder untouched
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !in_step |=> $stable(crc_q));

endmodule

// File: rtl/fcs_len_counter.sv
module fcs_len_counter #(
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_step,
    input  logic             in_first,
    output logic [LEN_W-1:0] len_next
);
    localparam logic [LEN_W-1:0] LEN_TOP = '1;

    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] base;

    always_comb begin
        base     = in_first ? '0 : len_q;
        len_next = (base == LEN_TOP) ? base : base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          len_q <= '0;
        else if (in_step) len_q <= len_next;
    end

    p_len_sat_r7: assert property (@(posedge clk) disable iff (rst)
        (in_step && !in_first && len_q == LEN_TOP) |=> (len_q == LEN_TOP));

    p_len_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (in_step && in_first) |=> (len_q == 1));

endmodule

// File: rtl/fcs_event_counter.sv
module fcs_event_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                   cnt_q <= '0;
        else if (inc && cnt_q != CNT_TOP) cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

    p_sat_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_TOP && !clr) |=> (cnt_q == CNT_TOP));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/fcs_rx_checker.sv
module fcs_rx_checker
    import fcs_chk_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int CNT_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_byte,
    input  logic                 vlan_allow,
    output logic                 st_valid,
    output logic                 st_good,
    output logic                 st_crc_err,
    output logic                 st_runt,
    output logic                 st_giant,
    output logic                 st_jabber,
    input  logic                 cnt_clr,
    input  logic [RD_ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]     rd_data
);
    localparam logic [LEN_W-1:0] L_MIN     = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] L_MAX_STD = LEN_W'(MAX_FRAME);
    localparam logic [LEN_W-1:0] L_MAX_TAG = LEN_W'(MAX_FRAME + TAG_EXTRA);

    logic [31:0]      crc_next;
    logic [LEN_W-1:0] len_next;
    logic             eof_hit;
    logic             crc_bad;
    logic             oversize;
    fcs_status_t      cls;
    fcs_status_t      st_q;
    logic             st_valid_q;
    logic [EV_COUNT-1:0] ev_inc;
    logic [CNT_W-1:0]    cnt_vec [EV_COUNT];

    fcs_crc_engine u_crc (
        .clk      (clk),
        .rst      (rst),
        .in_step  (in_valid),
        .in_first (in_sof),
        .in_data  (in_byte),
        .crc_next (crc_next)
    );

    fcs_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst      (rst),
        .in_step  (in_valid),
        .in_first (in_sof),
        .len_next (len_next)
    );

    always_comb begin
        eof_hit     = in_valid && in_eof;
        crc_bad     = (crc_next ^ CRC_PRESET) != GOOD_RESIDUE;
        oversize    = len_next > (vlan_allow ? L_MAX_TAG : L_MAX_STD);
        cls.crc_err = crc_bad;
        cls.runt    = len_next < L_MIN;
        cls.giant   = oversize && !crc_bad;
        cls.jabber  = oversize && crc_bad;
        cls.good    = !(crc_bad || oversize || (len_next < L_MIN));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_valid_q <= 1'b0;
        end else begin
            st_q       <= eof_hit ? cls : '0;
            st_valid_q <= eof_hit;
        end
    end

    assign st_valid   = st_valid_q;
    assign st_good    = st_q.good;
    assign st_crc_err = st_q.crc_err;
    assign st_runt    = st_q.runt;
    assign st_giant   = st_q.giant;
    assign st_jabber  = st_q.jabber;

    always_comb begin
        ev_inc            = '0;
        ev_inc[EV_GOOD]   = eof_hit && cls.good;
        ev_inc[EV_CRC]    = eof_hit && cls.crc_err;
        ev_inc[EV_RUNT]   = eof_hit && cls.runt;
        ev_inc[EV_GIANT]  = eof_hit && cls.giant;
        ev_inc[EV_JABBER] = eof_hit && cls.jabber;
    end

    for (genvar g = 0; g < EV_COUNT; g++) begin : g_evt
        fcs_event_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (cnt_clr),
            .inc   (ev_inc[g]),
            .count (cnt_vec[g])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < EV_COUNT; k++) begin
            if (rd_addr == RD_ADDR_W'(k)) rd_data = cnt_vec[k];
        end
    end

    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (st_valid == $past(in_valid && in_eof)));

    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !st_valid |-> (st_q == '0));

    p_good_alone_r6: assert property (@(posedge clk) disable iff (rst)
        st_good |-> !(st_crc_err || st_runt || st_giant || st_jabber));

    p_jabber_r5: assert property (@(posedge clk) disable iff (rst)
        st_jabber |-> (st_crc_err && !st_giant));

    p_giant_r4: assert property (@(posedge clk) disable iff (rst)
        st_giant |-> !st_crc_err);

endmodule

// File: tb/fcs_rx_checker_test.sv
module fcs_rx_checker_test;
    import fcs_chk_pkg::*;

    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_byte = '0;
    logic vlan_allow = 1'b0;
    logic cnt_clr = 1'b0;
    logic [2:0] rd_addr = '0;
    logic st_valid, st_good, st_crc_err, st_runt, st_giant, st_jabber;
    logic [CW-1:0] rd_data;

    int checks = 0;
    int errors = 0;
    int model [5];
    logic [7:0] frm [0:2199];

    always #5 clk = ~clk;

    fcs_rx_checker #(.LEN_W(11), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_byte(in_byte), .vlan_allow(vlan_allow), .st_valid(st_valid), .st_good(st_good),
        .st_crc_err(st_crc_err), .st_runt(st_runt), .st_giant(st_giant), .st_jabber(st_jabber),
        .cnt_clr(cnt_clr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reflected-form CRC without final complement; independent of the RTL form.
    function automatic logic [31:0] refl_raw(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'd0, frm[i]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return c;
    endfunction

    // n = total length including 4 check bytes
    task automatic build(input int n, input int seed);
        logic [31:0] f;
        for (int i = 0; i < n; i++) frm[i] = 8'((i * 37 + seed * 11 + 5) & 255);
        if (n >= 4) begin
            f = ~refl_raw(n - 4);
            for (int k = 0; k < 4; k++) frm[n - 4 + k] = f[8*k +: 8];
        end
    endtask

    task automatic flip(input int b);
        frm[b / 8][b % 8] = ~frm[b / 8][b % 8];
    endtask

    task automatic send(input int n, input bit vlan, input bit gaps, input bit clr_end,
                        input string tag);
        bit bad, runt, over, gi, ja, good;
        logic [5:0] exp_v, act_v;
        string req;
        vlan_allow = vlan;
        for (int i = 0; i < n; i++) begin
            if (gaps && (i % 7 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_byte = 8'hA5;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == n - 1);
            in_byte  = frm[i];
            cnt_clr  = clr_end && (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cnt_clr = 1'b0;
        bad  = refl_raw(n) != 32'hDEBB_20E3;
        runt = n < 64;
        over = n > (vlan ? 1522 : 1518);
        gi   = over && !bad;
        ja   = over && bad;
        good = !(bad || runt || over);
        exp_v = {1'b1, good, bad, runt, gi, ja};
        act_v = {st_valid, st_good, st_crc_err, st_runt, st_giant, st_jabber};
        if (ja)        req = "R5";
        else if (gi)   req = "R4";
        else if (runt) req = "R3";
        else if (bad)  req = "R2";
        else           req = "R1";
        chk(act_v == exp_v, {req, " status ", tag}, int'(act_v), int'(exp_v));
        if (clr_end) begin
            for (int k = 0; k < 5; k++) model[k] = 0;
        end else begin
            if (good) model[0]++;
            if (bad)  model[1]++;
            if (runt) model[2]++;
            if (gi)   model[3]++;
            if (ja)   model[4]++;
        end
        @(negedge clk);
        chk(st_valid == 1'b0 && st_crc_err == 1'b0 && st_good == 1'b0,
            "R6 single-cycle status", int'(st_valid), 0);
    endtask

    task automatic check_counters(input string tag);
        int e;
        for (int a = 0; a < 8; a++) begin
            rd_addr = 3'(a);
            #1;
            e = (a < 5) ? ((model[a] > CMAX) ? CMAX : model[a]) : 0;
            chk(int'(rd_data) == e, {"R8/R9 counter ", tag}, int'(rd_data), e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lens [13] = '{1, 3, 4, 5, 63, 64, 65, 100, 1518, 1519, 1522, 1523, 2100};
        for (int k = 0; k < 5; k++) model[k] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(st_valid == 1'b0 && st_good == 1'b0, "R6 reset state", int'(st_valid), 0);
        check_counters("after reset");

        // Length sweep around each boundary, intact and corrupted, both limits.
        foreach (lens[li]) begin
            for (int v = 0; v < 2; v++) begin
                for (int c = 0; c < 2; c++) begin
                    build(lens[li], li + v);
                    if (c == 1) flip((lens[li] / 2) * 8 + 3);
                    send(lens[li], v[0], 1'b0, 1'b0, lens[li] == 2100 ? "R7 saturated length" : "sweep");
                end
            end
        end
        check_counters("after sweep");

        // Clear coinciding with end of frame.
        build(64, 3);
        send(64, 1'b0, 1'b0, 1'b1, "R10 clear at eof");
        check_counters("R10 after clear");
        build(64, 4);
        send(64, 1'b0, 1'b0, 1'b0, "R10 resume");
        check_counters("R10 resume");

        // Gapped valid strobe with stray markers while idle.
        build(80, 9);
        send(80, 1'b0, 1'b1, 1'b0, "R11 gaps");
        build(70, 10);
        flip(200);
        send(70, 1'b0, 1'b1, 1'b0, "R11 gaps bad");

        // Every single-bit flip of a minimum frame.
        for (int b = 0; b < 512; b++) begin
            build(64, 5);
            flip(b);
            send(64, 1'b0, 1'b0, 1'b0, "R2 single flip");
        end
        // Double flips.
        for (int i = 0; i < 64; i++) begin
            build(64, 6);
            flip(i * 7);
            flip((i * 7 + (i % 40) + 1) % 512);
            send(64, 1'b0, 1'b0, 1'b0, "R2 double flip");
        end
        // Bursts of 2..32 bits.
        for (int len = 2; len <= 32; len++) begin
            for (int p = 0; p < 3; p++) begin
                int st;
                st = (p == 0) ? 0 : (p == 1) ? 100 : 512 - len;
                build(64, 7 + p);
                flip(st);
                flip(st + len - 1);
                for (int m = 1; m < len - 1; m++) if (((m * 5 + len) % 3) == 0) flip(st + m);
                send(64, 1'b0, 1'b0, 1'b0, "R2 burst");
            end
        end
        check_counters("R9 saturated");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule